// File: doc/BRIEF.md
# Line-Card Access Switch Controller

This block is the digital control for a solid-state access switch on an analog telephone line card. The switch has four poles: a pair of line-break switches that join the subscriber line to the line driver, a ringing-return switch, and a ringing switch that brings in the ringing generator. The controller turns a small set of logic inputs into registered enables for those poles. The inputs are a ringing-select level, a latch-enable level and an active-low shutdown request. Three flags come from analog circuits elsewhere: over-temperature, battery-valid (hysteresis applied upstream) and a one-cycle ringing-current zero-crossing strobe.

There are three settled states: talk, ringing and all-off. A transparent data latch can freeze the ringing-select command. The shutdown request does not pass through that latch and overrides it. The ringing switch carries AC ringing current, so once it is closed it only opens at a zero crossing of that current. This gives two ways to leave ringing. Dropping ringing-select gives make-before-break: the line-break poles close while the ringing switch is still waiting to open. Pulling shutdown low gives break-before-make: all poles except the ringing switch open, and talk is entered only after the shutdown request is released. The same over-temperature flag also drives an active-low shutdown status output.

Top module: `lac_ctrl`

## Requirements
- R1: In talk all line-break enables are 1 and the ringing-return and ringing enables are 0. In ringing the line-break enables are 0 and the other two are 1. In all-off all four enables are 0 (a ringing enable still waiting for a zero crossing is the only exception, see R5).
- R2: With latch-enable at 0 and no forcing condition, ringing-select 0 selects talk and 1 selects ringing. The enables are registered and show the new state after the first rising clock edge that sees the inputs.
- R3: While latch-enable is 0 the latch is transparent. While it is 1, the command is the ringing-select value sampled at the last rising edge at which latch-enable was 0, and changes on ringing-select have no effect on the enables.
- R4: Shutdown input at 0 forces the line-break and ringing-return enables to 0 at the next edge, whatever latch-enable and ringing-select are. On release the state selected by the (possibly latched) command returns.
- R5: Once the ringing enable is 1 it goes to 0 only at an edge where the zero-crossing strobe is 1 and ringing is not commanded. A strobe while ringing is commanded has no effect, and re-entering ringing cancels a pending release.
- R6: Make-before-break: when ringing-select drops to 0 during ringing, at the next edge the line-break enables go to 1, ringing-return goes to 0 and the ringing enable stays 1 until the zero crossing. The block then rests in talk.
- R7: Break-before-make: when shutdown goes low during ringing, the line-break and ringing-return enables are 0 at the next edge and the ringing enable opens at the zero crossing. Releasing shutdown with ringing-select 0 enters talk.
- R8: Over-temperature 1 forces all-off and sets the shutdown status output to 0 at the next edge. Both recover one edge after the flag clears.
- R9: Battery-valid 0 forces all-off until the flag returns to 1.
- R10: Asynchronous reset sets all enables to 0, the status output to 1 and the latched command to 0 (talk).
- R11: A line-break enable and the ringing enable are both 1 only when the ringing switch was already closed in the cycle before. In that case the ringing-return enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sel_i | input | 1 | 1 requests ringing, 0 requests talk |
| hold_i | input | 1 | Latch enable: 1 freezes the command |
| shdn_n_i | input | 1 | Active-low shutdown request, bypasses the latch |
| overtemp_i | input | 1 | Over-temperature flag from the thermal sensor |
| batt_ok_i | input | 1 | Battery-valid flag with hysteresis applied upstream |
| zc_pulse_i | input | 1 | One-cycle ringing-current zero-crossing strobe |
| brk_en_o | output | NUM_BRK | Line-break switch enables |
| rret_en_o | output | 1 | Ringing-return switch enable |
| rgen_en_o | output | 1 | Ringing switch enable |
| shdn_stat_n_o | output | 1 | Active-low thermal shutdown status |

## Verification
Some rules are checked by assertions on every cycle. The ringing switch never opens without a zero-crossing strobe. Any forcing condition clears the line-break and ringing-return enables one edge later. Over-temperature pulls the status low. A held latch keeps the command stable. A line-break and ringing overlap only ever continues a ringing switch that was already closed. Other behaviour only the bench scenarios can show: the full make-before-break and break-before-make sequences, which value the latch captures when it closes, a pending release being cancelled by a return to ringing, and the latched command being cleared by reset.

// File: rtl/lac_pkg.sv
package lac_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_TALK = 2'd1,
        MODE_RING = 2'd2
    } lac_mode_e;

    typedef struct packed {
        logic brk;
        logic rret;
        logic stat_n;
    } lac_ctl_t;

    localparam lac_ctl_t LAC_CTL_RESET = '{brk: 1'b0, rret: 1'b0, stat_n: 1'b1};

endpackage

// File: rtl/lac_sel_latch.sv
module lac_sel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic hold_i,
    output logic sel_o
);

    logic held_d, held_q;

    // Capture follows the input while the latch is open; freezes when held.
    always_comb begin
        held_d = held_q;
        if (!hold_i) begin
            held_d = sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= held_d;
        end
    end

    assign sel_o = hold_i ? held_q : sel_i;

    // R3: a command held across two cycles does not move
    assert_held_stable_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i)) |-> $stable(sel_o)
    );

endmodule

// File: rtl/lac_ring_release.sv
module lac_ring_release (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_cmd_i,
    input  logic zc_i,
    output logic rgen_o
);

    logic rgen_d, rgen_q;

    // Closed on command; once closed, opens only at a zero crossing when
    // ringing is no longer requested. A renewed command cancels the wait.
    always_comb begin
        rgen_d = rgen_q;
        if (ring_cmd_i) begin
            rgen_d = 1'b1;
        end else if (rgen_q && zc_i) begin
            rgen_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgen_q <= 1'b0;
        end else begin
            rgen_q <= rgen_d;
        end
    end

    assign rgen_o = rgen_q;

    // R5: the ringing switch never opens without a zero-crossing strobe
    assert_open_at_zc_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(rgen_q) |-> $past(zc_i)
    );

    // R5: a strobe with no ringing command releases a closed switch
    assert_release_on_zc_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rgen_q && zc_i && !ring_cmd_i) |=> !rgen_q
    );

endmodule

// File: rtl/lac_ctrl.sv
module lac_ctrl #(
    parameter int NUM_BRK = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ring_sel_i,
    input  logic               hold_i,
    input  logic               shdn_n_i,
    input  logic               overtemp_i,
    input  logic               batt_ok_i,
    input  logic               zc_pulse_i,
    output logic [NUM_BRK-1:0] brk_en_o,
    output logic               rret_en_o,
    output logic               rgen_en_o,
    output logic               shdn_stat_n_o
);

    import lac_pkg::*;

    localparam int BRK_W = (NUM_BRK < 1) ? 1 : NUM_BRK;

    logic      sel_eff;
    logic      force_off;
    lac_mode_e mode;
    logic      ring_cmd;
    lac_ctl_t  ctl_d, ctl_q;

    lac_sel_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (ring_sel_i),
        .hold_i (hold_i),
        .sel_o  (sel_eff)
    );

    // Shutdown, heat and battery loss bypass the latch entirely.
    always_comb begin
        force_off = !shdn_n_i || overtemp_i || !batt_ok_i;
        if (force_off) begin
            mode = MODE_OFF;
        end else if (sel_eff) begin
            mode = MODE_RING;
        end else begin
            mode = MODE_TALK;
        end
        ring_cmd = (mode == MODE_RING);

        ctl_d        = ctl_q;
        ctl_d.brk    = (mode == MODE_TALK);
        ctl_d.rret   = (mode == MODE_RING);
        ctl_d.stat_n = !overtemp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= LAC_CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lac_ring_release u_rgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_cmd_i (ring_cmd),
        .zc_i       (zc_pulse_i),
        .rgen_o     (rgen_en_o)
    );

    genvar gi;
    generate
        for (gi = 0; gi < BRK_W; gi++) begin : g_brk
            assign brk_en_o[gi] = ctl_q.brk;
        end
    endgenerate

    assign rret_en_o     = ctl_q.rret;
    assign shdn_stat_n_o = ctl_q.stat_n;

    // R4: any forcing condition opens break and return poles next edge
    assert_force_opens_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!shdn_n_i || overtemp_i || !batt_ok_i) |=> (brk_en_o == '0 && !rret_en_o)
    );

    // R8: thermal event reported on the status output
    assert_hot_status_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        overtemp_i |=> !shdn_stat_n_o
    );

    // R11: break/ringing overlap only continues an already closed ringing switch
    assert_overlap_mbb_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (brk_en_o[0] && rgen_en_o) |-> ($past(rgen_en_o) && !rret_en_o)
    );

endmodule

// File: tb/sim_lac_ctrl.sv
`timescale 1ns/1ps
module sim_lac_ctrl;

    localparam int NB = 2;
    localparam int NV = 28;

    // Vector: {ring, hold, shdn_n, ot, bat, zc} _ {brk, rret, rgen, stat_n}
    localparam logic [9:0] VEC [NV] = '{
        10'b001010_1001, // 0  R2 talk
        10'b101010_0111, // 1  R2 ringing
        10'b111010_0111, // 2  R3 latch closes on 1
        10'b011010_0111, // 3  R3 select change ignored
        10'b001010_1011, // 4  R6 make-before-break, rgen waits
        10'b001010_1011, // 5  R6 still waiting
        10'b001011_1001, // 6  R6 zero crossing -> talk
        10'b101010_0111, // 7  R1 ringing again
        10'b100010_0011, // 8  R7 shutdown: only rgen left
        10'b100011_0001, // 9  R7 opens at zc
        10'b001010_1001, // 10 R7 release -> talk
        10'b001110_0000, // 11 R8 hot -> all-off, status low
        10'b001010_1001, // 12 R8 recovers
        10'b101010_0111, // 13 ringing
        10'b101000_0011, // 14 R9 battery lost
        10'b101001_0001, // 15 R9 opens at zc
        10'b101010_0111, // 16 R9 battery back
        10'b101011_0111, // 17 R5 zc ignored while ringing
        10'b011010_0111, // 18 R3 latch holds 1
        10'b010010_0011, // 19 R4 shutdown over latch
        10'b011010_0111, // 20 R4 release -> latched ringing
        10'b001010_1011, // 21 open latch -> MBB
        10'b001011_1001, // 22 zc -> talk
        10'b101010_0111, // 23 ringing
        10'b001010_1011, // 24 release pending
        10'b101010_0111, // 25 R5 re-enter ringing cancels
        10'b101011_0111, // 26 R5 zc ignored
        10'b001010_1011  // 27 R5 new release still waits
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_sel = 1'b0, hold = 1'b0, shdn_n = 1'b1;
    logic overtemp = 1'b0, batt_ok = 1'b1, zc = 1'b0;
    logic [NB-1:0] brk;
    logic rret, rgen, stat_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lac_ctrl #(.NUM_BRK(NB)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ring_sel_i    (ring_sel),
        .hold_i        (hold),
        .shdn_n_i      (shdn_n),
        .overtemp_i    (overtemp),
        .batt_ok_i     (batt_ok),
        .zc_pulse_i    (zc),
        .brk_en_o      (brk),
        .rret_en_o     (rret),
        .rgen_en_o     (rgen),
        .shdn_stat_n_o (stat_n)
    );

    task automatic check(input string req, input logic eb, input logic er,
                         input logic eg, input logic es);
        logic [4:0] act, exp;
        act = {brk, rret, rgen, stat_n};
        exp = {{NB{eb}}, er, eg, es};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got brk=%b rret=%b rgen=%b stat=%b, want brk=%b rret=%b rgen=%b stat=%b",
                     req, brk, rret, rgen, stat_n, {NB{eb}}, er, eg, es);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        {ring_sel, hold, shdn_n, overtemp, batt_ok, zc} = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        #12;
        @(negedge clk);
        check("R10 reset", 1'b0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][9:4]);
            @(negedge clk);
            check($sformatf("vec%0d", i), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R10: reset mid-ringing clears everything at once
        @(negedge clk);
        drive(6'b101010);
        @(negedge clk);
        check("R1 ringing before reset", 1'b0, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R10 async reset", 1'b0, 1'b0, 1'b0, 1'b1);

        // R10: latched command cleared by reset; hold high from the start
        drive(6'b111010);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 latch cleared -> talk", 1'b1, 1'b0, 1'b0, 1'b1);
        drive(6'b101010);
        @(negedge clk);
        check("R2 hold released -> ringing", 1'b0, 1'b1, 1'b1, 1'b1);

        // R8 + R7: hot during ringing keeps rgen until zc, status low
        drive(6'b101110);
        @(negedge clk);
        check("R8 hot in ringing", 1'b0, 1'b0, 1'b1, 1'b0);
        drive(6'b101111);
        @(negedge clk);
        check("R8 zc opens rgen", 1'b0, 1'b0, 1'b0, 1'b0);
        drive(6'b001010);
        @(negedge clk);
        check("R8 cooled -> talk", 1'b1, 1'b0, 1'b0, 1'b1);

        // R5: zc with switch already open has no effect
        drive(6'b001011);
        @(negedge clk);
        check("R5 zc in talk", 1'b1, 1'b0, 1'b0, 1'b1);

        drive(6'b001010);
        @(negedge clk);
        finish_run();
    end

endmodule